// File: doc/BRIEF.md
# UART Interrupt Identification

This block is the interrupt part of a 16550-style UART register file. It keeps the interrupt enable byte, the two divisor latch bytes and a transmitter-empty pending flag. It decides which interrupt source to report, and it drives a level interrupt line. Byte reads and writes arrive on a 3-bit address bus, one access per cycle with `acc_valid` high. Read data is combinational in the cycle of the access. The line status error, receive data ready and modem status change conditions come from the rest of the UART as plain inputs, together with the FIFO-enable bit and the divisor latch select bit of the line control register.

The reported source is chosen again on every read by fixed priority. The transmitter-empty condition is held by a two-state machine with states `THRE_ARMED` and `THRE_IDLE`:

- Reset leaves it in `THRE_ARMED`.
- The transition `clear` (`THRE_ARMED` to `THRE_IDLE`) is taken when an identification read reports transmitter-empty.
- The transition `rearm` (`THRE_IDLE` to `THRE_ARMED`) is taken on an enable write in which the transmit-empty enable bit is set both in the new value and in the value held before the write.

Every other case keeps the state. The interrupt output is a register. It is loaded only on a cycle with an access, from the state as it stands after that access.

Top module: `uart_irq_ident`

## Requirements
- R1: Sources rank from highest to lowest as follows: line status error, receive data ready, transmitter empty, modem status change. The identification byte carries the code of the highest-ranked source that qualifies, in bits 3:1 with bit 0 clear. The codes are 3'b011 for line status, 3'b010 for receive data, 3'b001 for transmitter empty and 3'b000 for modem status.
- R2: A source qualifies only when its enable bit and its condition are both set. Enable bit 0 is receive data, bit 1 is transmitter empty, bit 2 is line status and bit 3 is modem status.
- R3: When no source qualifies, the identification byte has bit 0 set and bits 3:1 clear.
- R4: Identification bits 7:6 both equal `fifo_en`. Bits 5:4 read as zero.
- R5: An identification read that reports transmitter-empty clears the pending flag. A following read, with nothing else changed, no longer reports it.
- R6: An enable write sets the pending flag again only when bit 1 is set in both the written value and the value held before the write. A write that sets bit 1 from 0 does not re-arm the flag.
- R7: An enable write stores bits 3:0 only. Reads of the enable register return bits 7:4 as zero.
- R8: While `dlab` is 1, address 0 reads and writes the divisor low byte and address 1 the divisor high byte. The enable register is left untouched. Address 2 always reads the identification byte.
- R9: After reset the enable register is 0, the divisor is `DIV_RESET` (default 0x000C), the transmitter-empty flag is pending and `irq` is low.
- R10: `irq` changes only in the cycle after an access. It then shows whether a source qualifies in the state left by that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (3) | Register address |
| acc_wdata | input | DATA_W (8) | Write data |
| acc_rdata | output | DATA_W (8) | Read data, valid in the access cycle |
| dlab | input | 1 | Divisor latch select from the line control register |
| fifo_en | input | 1 | FIFO enable bit from the FIFO control register |
| lsr_err | input | 1 | Line status error condition |
| rx_avail | input | 1 | Receive data ready condition |
| msr_chg | input | 1 | Modem status change condition |
| irq | output | 1 | Level interrupt output |

## Verification
The assertions take these things for granted:
- At most one access arrives per cycle.
- The address, write data and status inputs are known and held steady throughout an access cycle.
- The checker samples the combinational read data at the same clock edge that moves the pending flag.

The stimulus drives every input on the falling edge and holds it for the whole high phase. Status inputs change only between accesses, so every identification read sees one settled set of conditions. Setup accesses run with all conditions low, so that no read clears the flag by accident.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC = 4;

    // Enable register bit positions
    localparam int EN_RXD = 0;
    localparam int EN_THR = 1;
    localparam int EN_LSR = 2;
    localparam int EN_MSR = 3;
    localparam int IER_W  = 4;

    // Register addresses
    localparam int REG_A0 = 0;
    localparam int REG_A1 = 1;
    localparam int REG_A2 = 2;

    // Source rank: lower value wins
    typedef enum logic [2:0] {
        SRC_LSR  = 3'd0,
        SRC_RXD  = 3'd1,
        SRC_THR  = 3'd2,
        SRC_MSR  = 3'd3,
        SRC_NONE = 3'd4
    } src_e;

    typedef enum logic {
        THRE_IDLE  = 1'b0,
        THRE_ARMED = 1'b1
    } thre_state_e;

    function automatic logic [1:0] enable_bit(input int unsigned rank);
        case (rank)
            0:       return 2'(EN_LSR);
            1:       return 2'(EN_RXD);
            2:       return 2'(EN_THR);
            default: return 2'(EN_MSR);
        endcase
    endfunction

    function automatic logic [2:0] src_code(input src_e s);
        case (s)
            SRC_LSR: return 3'b011;
            SRC_RXD: return 3'b010;
            SRC_THR: return 3'b001;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic [7:0] iir_byte(input src_e s, input logic fifo_on);
        logic [7:0] b;
        b = 8'h00;
        if (s == SRC_NONE) b[0] = 1'b1;
        else               b[3:1] = src_code(s);
        b[7:6] = {2{fifo_on}};
        return b;
    endfunction

endpackage

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [IER_W-1:0]   ier,
    input  logic [NUM_SRC-1:0] cond,
    output src_e               src
);

    // Scan from the lowest rank upward so the highest qualifying rank is left
    always_comb begin
        src = SRC_NONE;
        for (int r = NUM_SRC - 1; r >= 0; r--) begin
            if (ier[enable_bit(r)] && cond[r]) src = src_e'(3'(r));
        end
    end

endmodule

// File: rtl/uart_thre_fsm.sv
module uart_thre_fsm
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_req,
    input  logic rearm_req,
    output logic pending_q,
    output logic pending_next
);

    thre_state_e state, state_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= THRE_ARMED;
        else        state <= state_next;
    end

    always_comb begin
        state_next = state;
        unique case (state)
            THRE_ARMED: if (clear_req) state_next = THRE_IDLE;
            THRE_IDLE:  if (rearm_req) state_next = THRE_ARMED;
        endcase
    end

    always_comb begin
        pending_q    = (state == THRE_ARMED);
        pending_next = (state_next == THRE_ARMED);
    end

endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
    import uart_irq_pkg::*;
#(
    parameter int               DATA_W    = 8,
    parameter logic [2*DATA_W-1:0] DIV_RESET = 16'h000C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ier,
    input  logic              wr_dll,
    input  logic              wr_dlm,
    input  logic [DATA_W-1:0] wdata,
    output logic [IER_W-1:0]  ier_q,
    output logic [IER_W-1:0]  ier_next,
    output logic [DATA_W-1:0] dll_q,
    output logic [DATA_W-1:0] dlm_q
);

    always_comb ier_next = wr_ier ? wdata[IER_W-1:0] : ier_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ier_q <= '0;
            dll_q <= DIV_RESET[DATA_W-1:0];
            dlm_q <= DIV_RESET[2*DATA_W-1:DATA_W];
        end else begin
            ier_q <= ier_next;
            if (wr_dll) dll_q <= wdata;
            if (wr_dlm) dlm_q <= wdata;
        end
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int                  ADDR_W    = 3,
    parameter int                  DATA_W    = 8,
    parameter logic [2*DATA_W-1:0] DIV_RESET = 16'h000C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic              dlab,
    input  logic              fifo_en,
    input  logic              lsr_err,
    input  logic              rx_avail,
    input  logic              msr_chg,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A0 = ADDR_W'(REG_A0);
    localparam logic [ADDR_W-1:0] A1 = ADDR_W'(REG_A1);
    localparam logic [ADDR_W-1:0] A2 = ADDR_W'(REG_A2);

    logic              is_rd, is_wr;
    logic              wr_ier, wr_dll, wr_dlm, rd_iir;
    logic [IER_W-1:0]  ier_q, ier_next;
    logic [DATA_W-1:0] dll_q, dlm_q;
    logic              thre_pend, thre_pend_next;
    logic              clear_req, rearm_req;
    src_e              src_now, src_after;
    logic [7:0]        iir_now;
    logic              irq_q;

    always_comb begin
        is_rd  = acc_valid && !acc_write;
        is_wr  = acc_valid &&  acc_write;
        wr_ier = is_wr && !dlab && (acc_addr == A1);
        wr_dll = is_wr &&  dlab && (acc_addr == A0);
        wr_dlm = is_wr &&  dlab && (acc_addr == A1);
        rd_iir = is_rd && (acc_addr == A2);
    end

    uart_irq_regs #(.DATA_W(DATA_W), .DIV_RESET(DIV_RESET)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ier   (wr_ier),
        .wr_dll   (wr_dll),
        .wr_dlm   (wr_dlm),
        .wdata    (acc_wdata),
        .ier_q    (ier_q),
        .ier_next (ier_next),
        .dll_q    (dll_q),
        .dlm_q    (dlm_q)
    );

    // Identity as seen by the current access
    uart_irq_prio u_prio_now (
        .ier  (ier_q),
        .cond ({msr_chg, thre_pend, rx_avail, lsr_err}),
        .src  (src_now)
    );

    always_comb begin
        iir_now   = iir_byte(src_now, fifo_en);
        clear_req = rd_iir && (src_now == SRC_THR);
        rearm_req = wr_ier && acc_wdata[EN_THR] && ier_q[EN_THR];
    end

    uart_thre_fsm u_thre (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_req    (clear_req),
        .rearm_req    (rearm_req),
        .pending_q    (thre_pend),
        .pending_next (thre_pend_next)
    );

    // Identity once the current access has taken effect
    uart_irq_prio u_prio_after (
        .ier  (ier_next),
        .cond ({msr_chg, thre_pend_next, rx_avail, lsr_err}),
        .src  (src_after)
    );

    always_comb begin
        acc_rdata = '0;
        if (is_rd) begin
            case (acc_addr)
                A0: if (dlab) acc_rdata = dll_q;
                A1: acc_rdata = dlab ? dlm_q : DATA_W'(ier_q);
                A2: acc_rdata = DATA_W'(iir_now);
                default: acc_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         irq_q <= 1'b0;
        else if (acc_valid) irq_q <= (src_after != SRC_NONE);
    end

    assign irq = irq_q;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic       acc_write,
    input logic [2:0] acc_addr,
    input logic [7:0] acc_wdata,
    input logic [7:0] acc_rdata,
    input logic       dlab,
    input logic       fifo_en,
    input logic       lsr_err,
    input logic       irq,
    input logic [3:0] ier_q,
    input logic       thre_pend
);

    logic rd_id, rd_en, wr_en;
    assign rd_id = acc_valid && !acc_write && acc_addr == 3'd2;
    assign rd_en = acc_valid && !acc_write && acc_addr == 3'd1 && !dlab;
    assign wr_en = acc_valid &&  acc_write && acc_addr == 3'd1 && !dlab;

    assert_lsr_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_id && lsr_err && ier_q[2] |-> acc_rdata[3:0] == 4'h6);

    assert_disabled_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_id && ier_q == 4'h0 |-> acc_rdata[0]);

    assert_none_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_id && acc_rdata[0] |-> acc_rdata[3:1] == 3'b000);

    assert_fifo_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_id |-> acc_rdata[7:6] == {2{fifo_en}} && acc_rdata[5:4] == 2'b00);

    assert_thre_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_id && acc_rdata[3:0] == 4'h2 |=> !thre_pend);

    assert_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && acc_wdata[1] && ier_q[1] |=> thre_pend);

    assert_ier_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> acc_rdata[7:4] == 4'h0);

    assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(irq));

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .dlab      (dlab),
    .fifo_en   (fifo_en),
    .lsr_err   (lsr_err),
    .irq       (irq),
    .ier_q     (ier_q),
    .thre_pend (thre_pend)
);

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_write = 1'b0;
    logic [2:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       dlab = 1'b0;
    logic       fifo_en = 1'b0;
    logic       lsr_err = 1'b0;
    logic       rx_avail = 1'b0;
    logic       msr_chg = 1'b0;
    logic       irq;

    int vecs = 0;
    int errs = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_ident u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .dlab(dlab), .fifo_en(fifo_en), .lsr_err(lsr_err), .rx_avail(rx_avail),
        .msr_chg(msr_chg), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [2:0] a, input logic [7:0] d,
                       output logic [7:0] r);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_wdata = d;
        #1 r = acc_rdata;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    // Bench model of the identification byte (R1..R4)
    function automatic logic [7:0] model_iir(input logic [3:0] ier, input logic l,
        input logic rx, input logic t, input logic m, input logic f);
        logic [7:0] b;
        if      (ier[2] && l)  b = 8'h06;
        else if (ier[0] && rx) b = 8'h04;
        else if (ier[1] && t)  b = 8'h02;
        else if (ier[3] && m)  b = 8'h00;
        else                   b = 8'h01;
        if (f) b = b | 8'hC0;
        return b;
    endfunction

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        check("R9 irq", {7'd0, irq}, 8'h00);
        acc(1'b0, 3'd1, 8'h00, r); check("R9 ier", r, 8'h00);
        dlab = 1'b1;
        acc(1'b0, 3'd0, 8'h00, r); check("R9 dll", r, 8'h0C);
        acc(1'b0, 3'd1, 8'h00, r); check("R9 dlm", r, 8'h00);
        dlab = 1'b0;
        acc(1'b1, 3'd1, 8'h02, r);
        acc(1'b0, 3'd2, 8'h00, r); check("R9 thre pending", r, 8'h02);
        // R5: read that reported transmitter-empty cleared it
        acc(1'b0, 3'd2, 8'h00, r); check("R5 cleared", r, 8'h01);

        // R6: 0 -> 1 does not re-arm, 1 -> 1 does
        acc(1'b1, 3'd1, 8'h00, r);
        acc(1'b1, 3'd1, 8'h02, r);
        acc(1'b0, 3'd2, 8'h00, r); check("R6 no rearm", r, 8'h01);
        acc(1'b1, 3'd1, 8'h02, r);
        acc(1'b0, 3'd2, 8'h00, r); check("R6 rearm", r, 8'h02);

        // R7: only low nibble stored
        acc(1'b1, 3'd1, 8'hFF, r);
        acc(1'b0, 3'd1, 8'h00, r); check("R7 mask", r, 8'h0F);
        acc(1'b1, 3'd1, 8'h00, r);

        // R8: divisor latch under dlab, enable register untouched
        dlab = 1'b1;
        acc(1'b1, 3'd0, 8'h34, r);
        acc(1'b1, 3'd1, 8'h12, r);
        acc(1'b0, 3'd0, 8'h00, r); check("R8 dll", r, 8'h34);
        acc(1'b0, 3'd1, 8'h00, r); check("R8 dlm", r, 8'h12);
        acc(1'b0, 3'd2, 8'h00, r); check("R8 ident", r, 8'h01);
        dlab = 1'b0;
        acc(1'b0, 3'd1, 8'h00, r); check("R8 ier kept", r, 8'h00);

        // R10: irq only moves on an access
        acc(1'b1, 3'd1, 8'h04, r);
        check("R10 idle", {7'd0, irq}, 8'h00);
        lsr_err = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 held", {7'd0, irq}, 8'h00);
        acc(1'b0, 3'd1, 8'h00, r);
        check("R10 updated", {7'd0, irq}, 8'h01);
        lsr_err = 1'b0;

        // Sweep: R1, R2, R3, R4, R5, R10 over all enables, conditions and FIFO modes
        for (int f = 0; f < 2; f++) begin
            for (int e = 0; e < 16; e++) begin
                for (int s = 0; s < 16; s++) begin
                    logic [3:0] ier, sb;
                    logic [7:0] exp_id, exp_after;
                    logic t_after;
                    ier = 4'(e); sb = 4'(s);
                    lsr_err = 1'b0; rx_avail = 1'b0; msr_chg = 1'b0; fifo_en = 1'b0;
                    acc(1'b1, 3'd1, 8'h02, r);
                    acc(1'b1, 3'd1, 8'h02, r);
                    if (!sb[2]) acc(1'b0, 3'd2, 8'h00, r);
                    acc(1'b1, 3'd1, 8'h00, r);
                    acc(1'b1, 3'd1, {4'h0, ier}, r);
                    lsr_err = sb[0]; rx_avail = sb[1]; msr_chg = sb[3]; fifo_en = f[0];
                    exp_id = model_iir(ier, sb[0], sb[1], sb[2], sb[3], f[0]);
                    acc(1'b0, 3'd2, 8'h00, r);
                    check("R1 ident", r, exp_id);
                    t_after = sb[2] && (exp_id[3:0] != 4'h2);
                    exp_after = model_iir(ier, sb[0], sb[1], t_after, sb[3], 1'b0);
                    check("R10 irq", {7'd0, irq}, {7'd0, ~exp_after[0]});
                end
            end
        end

        done = 1'b1;
        summary();
    end

endmodule